// File: doc/BRIEF.md
# Outbound Credit-Based Packet Scheduler

This block sits on the transmit side of a line card. Fixed-size pages arrive from the switch fabric, each tagged with a flow number and an end-of-packet flag. The block appends each page to a queue for its flow. A flow's packet counts as complete only when its last page has been stored. Which packet leaves next is decided by a fixed state machine. That machine does not arbitrate continuously: it acts only on four events, which are page arrival, a bandwidth-share update, a timer strobe and a transmit-ready pulse.

Each flow holds a credit balance. A timer strobe adds the flow's share to its balance, and the balance never rises above a cap. A share written through the configuration port is held as pending and is applied at the next timer strobe. Balances already earned are kept. When the transmit interface signals ready and nothing is being sent, the block picks a flow. The chosen flow must hold a complete packet and a nonzero balance, and must have the highest balance of all such flows. If several flows tie, the lowest flow number wins. The block then streams that packet out one page per cycle, and each page sent takes one unit of credit from its flow.

Top module: `oqs_sched`

## Requirements
- R1: After reset no page is output, and every credit balance and every share is zero. A ready pulse after reset therefore sends nothing, even when a packet is queued.
- R2: A flow becomes eligible only once the page with the end-of-packet flag has been stored. Pages leave in arrival order, one per cycle, with their flow number and end-of-packet flag. The first page appears in the cycle after the accepted ready pulse.
- R3: A flow is eligible only if it holds a complete packet and has a credit balance above zero. A ready pulse with no eligible flow has no effect.
- R4: Each timer strobe adds the flow's share to its balance, and the balance saturates at CREDIT_CAP.
- R5: Among the eligible flows, the one with the highest balance is chosen, and a tie goes to the lowest flow number.
- R6: A share write takes effect only at the next timer strobe. Writing a share does not change the balance already earned.
- R7: Every page transmitted lowers its flow's balance by one, and the balance never falls below zero.
- R8: Events in the same cycle are handled in this order: page arrival, share write, timer strobe, ready. A packet completed in the same cycle as the ready pulse can be chosen. A share written in the same cycle as a strobe is applied by that strobe. A strobe in the same cycle as the ready pulse counts toward that choice.
- R9: A ready pulse during a transmission is ignored. The next choice is made only after the last page has left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pg_valid | input | 1 | Page present on the input this cycle |
| pg_flow | input | FW | Flow number of the incoming page |
| pg_data | input | DW | Incoming page payload |
| pg_eop | input | 1 | Incoming page is the last page of its packet |
| cfg_we | input | 1 | Write a new share for one flow |
| cfg_flow | input | FW | Flow whose share is written |
| cfg_share | input | SW | New share value |
| tick | input | 1 | Timer strobe |
| tx_ready | input | 1 | Transmit interface can accept a packet |
| tx_valid | output | 1 | Page present on the output this cycle |
| tx_flow | output | FW | Flow number of the outgoing page |
| tx_data | output | DW | Outgoing page payload |
| tx_eop | output | 1 | Outgoing page is the last page of its packet |

## Verification
A page, share write or strobe applied in one cycle counts toward a ready pulse in that same cycle. The packet's first page appears one cycle after the ready pulse, and each later page follows one cycle behind the page before it. The bench drives every input on the falling edge and holds it for one rising edge. It reads the output on the next falling edge, so each check falls in the first cycle where the result is due. Queue state and balances are not visible at the ports. The bench therefore chooses queue contents and strobe counts so that each balance it relies on shows up as a difference in which flow is sent, or whether any flow is sent.

// File: rtl/oqs_pkg.sv
package oqs_pkg;

  typedef enum logic {ST_IDLE, ST_SEND} oqs_state_e;

  // Add a share, clamp at the cap, then remove one unit if a page left.
  function automatic logic [31:0] credit_step(input logic [31:0] cur,
                                              input logic [31:0] add,
                                              input logic [31:0] cap,
                                              input logic        take);
    logic [31:0] s;
    s = cur + add;
    if (s > cap) s = cap;
    if (take && s != 32'd0) s = s - 32'd1;
    return s;
  endfunction

endpackage

// File: rtl/oqs_page_store.sv
module oqs_page_store #(
  parameter int NF    = 4,
  parameter int DEPTH = 8,
  parameter int DW    = 16,
  localparam int FW   = (NF > 1) ? $clog2(NF) : 1,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CTW  = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [FW-1:0] wr_flow,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_eop,
  input  logic          rd_en,
  input  logic [FW-1:0] rd_flow,
  output logic [DW-1:0] rd_data,
  output logic          rd_eop,
  output logic [NF-1:0] pkt_avail
);

  logic [DW:0] head_vec [NF];

  for (genvar g = 0; g < NF; g++) begin : g_flow
    logic [DW:0]    mem [DEPTH];
    logic [PW-1:0]  wptr, rptr;
    logic [CTW-1:0] cnt, pkts;
    logic           push, pop, push_eop, pop_eop;

    assign push     = wr_en && (wr_flow == FW'(g)) && (cnt != CTW'(DEPTH));
    assign pop      = rd_en && (rd_flow == FW'(g)) && (cnt != '0);
    assign push_eop = push && wr_eop;
    assign pop_eop  = pop && mem[rptr][DW];
    assign head_vec[g] = mem[rptr];
    // completion in this cycle already counts (arrival precedes ready)
    assign pkt_avail[g] = (pkts != '0) || push_eop;

    always_ff @(posedge clk) begin
      if (push) mem[wptr] <= {wr_eop, wr_data};
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wptr <= '0;
        rptr <= '0;
        cnt  <= '0;
        pkts <= '0;
      end else begin
        if (push) wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + PW'(1);
        if (pop)  rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + PW'(1);
        cnt  <= cnt + CTW'(push) - CTW'(pop);
        pkts <= pkts + CTW'(push_eop) - CTW'(pop_eop);
      end
    end
  end

  assign rd_data = head_vec[rd_flow][DW-1:0];
  assign rd_eop  = head_vec[rd_flow][DW];

endmodule

// File: rtl/oqs_credit_bank.sv
module oqs_credit_bank #(
  parameter int NF  = 4,
  parameter int SW  = 4,
  parameter int CW  = 5,
  parameter int CAP = 20,
  localparam int FW = (NF > 1) ? $clog2(NF) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [FW-1:0]    cfg_flow,
  input  logic [SW-1:0]    cfg_share,
  input  logic             tick,
  input  logic             dec_en,
  input  logic [FW-1:0]    dec_flow,
  output logic [NF*CW-1:0] credit_flat,
  output logic [NF*CW-1:0] view_flat,
  output logic [NF*SW-1:0] share_flat
);

  for (genvar g = 0; g < NF; g++) begin : g_cred
    logic [SW-1:0] pend_q, pend_d, act_q;
    logic [CW-1:0] cred_q, view;
    logic          take;

    // share write is ordered before the timer in the same cycle
    assign pend_d = (cfg_we && cfg_flow == FW'(g)) ? cfg_share : pend_q;
    assign view   = tick ? CW'(oqs_pkg::credit_step(32'(cred_q), 32'(pend_d),
                                                    32'(CAP), 1'b0))
                         : cred_q;
    assign take   = dec_en && (dec_flow == FW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_q <= '0;
        act_q  <= '0;
        cred_q <= '0;
      end else begin
        pend_q <= pend_d;
        if (tick) act_q <= pend_d;
        cred_q <= CW'(oqs_pkg::credit_step(32'(view), 32'd0, 32'(CAP), take));
      end
    end

    assign credit_flat[g*CW +: CW] = cred_q;
    assign view_flat[g*CW +: CW]   = view;
    assign share_flat[g*SW +: SW]  = act_q;
  end

endmodule

// File: rtl/oqs_picker.sv
module oqs_picker #(
  parameter int NF  = 4,
  parameter int CW  = 5,
  localparam int FW = (NF > 1) ? $clog2(NF) : 1
) (
  input  logic [NF-1:0]    elig,
  input  logic [NF*CW-1:0] credit_flat,
  output logic             found,
  output logic [FW-1:0]    pick
);

  logic [CW-1:0] best;

  // strict greater-than keeps the lowest index on a tie
  always_comb begin
    found = 1'b0;
    pick  = '0;
    best  = '0;
    for (int i = 0; i < NF; i++) begin
      if (elig[i] && (!found || credit_flat[i*CW +: CW] > best)) begin
        found = 1'b1;
        pick  = FW'(i);
        best  = credit_flat[i*CW +: CW];
      end
    end
  end

endmodule

// File: rtl/oqs_sched.sv
module oqs_sched #(
  parameter int NF    = 4,
  parameter int DEPTH = 8,
  parameter int DW    = 16,
  parameter int SW    = 4,
  parameter int CW    = 5,
  parameter int CAP   = 20,
  localparam int FW   = (NF > 1) ? $clog2(NF) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pg_valid,
  input  logic [FW-1:0] pg_flow,
  input  logic [DW-1:0] pg_data,
  input  logic          pg_eop,
  input  logic          cfg_we,
  input  logic [FW-1:0] cfg_flow,
  input  logic [SW-1:0] cfg_share,
  input  logic          tick,
  input  logic          tx_ready,
  output logic          tx_valid,
  output logic [FW-1:0] tx_flow,
  output logic [DW-1:0] tx_data,
  output logic          tx_eop
);

  import oqs_pkg::*;

  oqs_state_e    state;
  logic [FW-1:0] sel_flow;

  // named event wires
  logic          evt_ready, start_evt, page_pop, pick_found;
  logic [FW-1:0] pick_flow;
  logic [NF-1:0] pkt_avail, elig;
  logic [NF*CW-1:0] credit_flat, view_flat;
  logic [NF*SW-1:0] share_flat;
  logic [DW-1:0] rd_data;
  logic          rd_eop;

  assign evt_ready = tx_ready && (state == ST_IDLE);
  assign start_evt = evt_ready && pick_found;
  assign page_pop  = (state == ST_SEND);

  oqs_page_store #(.NF(NF), .DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(pg_valid), .wr_flow(pg_flow), .wr_data(pg_data), .wr_eop(pg_eop),
    .rd_en(page_pop), .rd_flow(sel_flow),
    .rd_data(rd_data), .rd_eop(rd_eop), .pkt_avail(pkt_avail)
  );

  oqs_credit_bank #(.NF(NF), .SW(SW), .CW(CW), .CAP(CAP)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_flow(cfg_flow), .cfg_share(cfg_share),
    .tick(tick), .dec_en(page_pop), .dec_flow(sel_flow),
    .credit_flat(credit_flat), .view_flat(view_flat), .share_flat(share_flat)
  );

  for (genvar g = 0; g < NF; g++) begin : g_elig
    assign elig[g] = pkt_avail[g] && (view_flat[g*CW +: CW] != '0);
  end

  oqs_picker #(.NF(NF), .CW(CW)) u_pick (
    .elig(elig), .credit_flat(view_flat), .found(pick_found), .pick(pick_flow)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      sel_flow <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start_evt) begin
          state    <= ST_SEND;
          sel_flow <= pick_flow;
        end
        ST_SEND: if (rd_eop) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign tx_valid = page_pop;
  assign tx_flow  = sel_flow;
  assign tx_data  = rd_data;
  assign tx_eop   = rd_eop;

endmodule

// File: rtl/oqs_sched_chk.sv
module oqs_sched_chk #(
  parameter int NF  = 4,
  parameter int SW  = 4,
  parameter int CW  = 5,
  parameter int CAP = 20,
  localparam int FW = (NF > 1) ? $clog2(NF) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             tx_ready,
  input logic             tx_valid,
  input logic             tx_eop,
  input logic [FW-1:0]    tx_flow,
  input logic             start_evt,
  input logic [FW-1:0]    pick_flow,
  input logic [NF-1:0]    elig,
  input logic [NF*CW-1:0] credit_flat,
  input logic [NF*CW-1:0] view_flat,
  input logic [NF*SW-1:0] share_flat
);

  logic over_cap, worse_pick;
  logic [CW-1:0] pick_cr;

  assign pick_cr = view_flat[pick_flow*CW +: CW];

  always_comb begin
    over_cap   = 1'b0;
    worse_pick = 1'b0;
    for (int i = 0; i < NF; i++) begin
      if (32'(credit_flat[i*CW +: CW]) > 32'(CAP)) over_cap = 1'b1;
      if (start_evt && elig[i] &&
          (view_flat[i*CW +: CW] > pick_cr ||
           (view_flat[i*CW +: CW] == pick_cr && i < int'(pick_flow))))
        worse_pick = 1'b1;
    end
  end

  // R3
  pick_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> elig[pick_flow]);

  // R4
  credit_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !over_cap);

  // R5
  best_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !worse_pick);

  // R6
  share_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(share_flat));

  // R9
  pkt_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_eop) |=> (tx_valid && $stable(tx_flow)));

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |-> !start_evt);

endmodule

bind oqs_sched oqs_sched_chk #(.NF(NF), .SW(SW), .CW(CW), .CAP(CAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .tx_ready(tx_ready),
  .tx_valid(tx_valid), .tx_eop(tx_eop), .tx_flow(tx_flow),
  .start_evt(start_evt), .pick_flow(pick_flow), .elig(elig),
  .credit_flat(credit_flat), .view_flat(view_flat), .share_flat(share_flat)
);

// File: tb/oqs_sched_test.sv
`timescale 1ns/1ps
module oqs_sched_test;
  localparam int NF = 4, DW = 16, SW = 4, FW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pg_valid = 0, pg_eop = 0, cfg_we = 0, tick = 0, tx_ready = 0;
  logic [FW-1:0] pg_flow = '0, cfg_flow = '0;
  logic [DW-1:0] pg_data = '0;
  logic [SW-1:0] cfg_share = '0;
  logic tx_valid, tx_eop;
  logic [FW-1:0] tx_flow;
  logic [DW-1:0] tx_data;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  oqs_sched uut (.*);

  task automatic do_reset();
    rst_n = 0; pg_valid = 0; cfg_we = 0; tick = 0; tx_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic push(input int f, input int d, input bit e);
    pg_valid = 1; pg_flow = FW'(f); pg_data = DW'(d); pg_eop = e;
    @(negedge clk);
    pg_valid = 0;
  endtask

  task automatic set_share(input int f, input int s);
    cfg_we = 1; cfg_flow = FW'(f); cfg_share = SW'(s);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic pulse_tick();
    tick = 1; @(negedge clk); tick = 0;
  endtask

  task automatic pulse_ready();
    tx_ready = 1; @(negedge clk); tx_ready = 0;
  endtask

  task automatic chk_page(input string req, input int f, input int d, input bit e);
    n_chk++;
    if (!(tx_valid === 1'b1 && tx_flow === FW'(f) && tx_data === DW'(d) && tx_eop === e)) begin
      n_bad++;
      $display("FAIL %s: got v=%b f=%0d d=%h e=%b, expected v=1 f=%0d d=%h e=%b",
               req, tx_valid, tx_flow, tx_data, tx_eop, f, d, e);
    end
    @(negedge clk);
  endtask

  task automatic chk_idle(input string req);
    n_chk++;
    if (tx_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL %s: got tx_valid=%b, expected 0", req, tx_valid);
    end
  endtask

  // R1: nothing leaves after reset, credits start at zero
  task automatic t_reset();
    do_reset();
    chk_idle("R1 reset");
    push(0, 'h11, 1);
    pulse_ready();
    chk_idle("R1 zero credit after reset");
  endtask

  // R2, R3, R6: share pending until tick; partial packet not eligible
  task automatic t_alloc_reasm();
    do_reset();
    pulse_ready();
    chk_idle("R3 ready with empty queues");
    set_share(0, 3);
    push(0, 'hA0, 0);
    push(0, 'hA1, 1);
    pulse_ready();
    chk_idle("R6 share not applied before tick");
    pulse_tick();
    pulse_ready();
    chk_page("R2 page0", 0, 'hA0, 0);
    chk_page("R2 page1", 0, 'hA1, 1);
    chk_idle("R2 end of packet");
    set_share(1, 2);
    pulse_tick();
    push(1, 'hB0, 0);
    pulse_ready();
    chk_idle("R2 partial packet not eligible");
    push(1, 'hB1, 1);
    pulse_ready();
    chk_page("R2 reassembled page0", 1, 'hB0, 0);
    chk_page("R2 reassembled page1", 1, 'hB1, 1);
  endtask

  // R5, R7: tie to lowest id, then page charge moves the choice
  task automatic t_tie_charge();
    do_reset();
    set_share(1, 5);
    set_share(2, 5);
    push(2, 'hC2, 1);
    push(1, 'hC1, 1);
    push(1, 'hC3, 1);
    pulse_tick();
    pulse_ready();
    chk_page("R5 tie lowest id", 1, 'hC1, 1);
    pulse_ready();
    chk_page("R7 charged flow loses", 2, 'hC2, 1);
    pulse_ready();
    chk_page("R7 remaining packet", 1, 'hC3, 1);
  endtask

  // R5: highest credit wins
  task automatic t_highest();
    do_reset();
    set_share(0, 2);
    set_share(3, 6);
    push(0, 'hD0, 1);
    push(3, 'hD3, 1);
    pulse_tick();
    pulse_ready();
    chk_page("R5 highest credit", 3, 'hD3, 1);
  endtask

  // R4: saturation at cap 20 equalizes shares 5 and 6 after four ticks
  task automatic t_cap();
    do_reset();
    set_share(1, 5);
    set_share(2, 6);
    push(2, 'hE2, 1);
    push(1, 'hE1, 1);
    repeat (4) pulse_tick();
    pulse_ready();
    chk_page("R4 cap makes tie", 1, 'hE1, 1);
  endtask

  // R6: credit kept after share change
  task automatic t_keep();
    do_reset();
    set_share(0, 4);
    set_share(1, 3);
    push(0, 'hF0, 1);
    push(1, 'hF1, 1);
    pulse_tick();
    set_share(0, 0);
    pulse_tick();
    pulse_ready();
    chk_page("R6 new shares applied", 1, 'hF1, 1);
    pulse_ready();
    chk_page("R6 earned credit kept", 0, 'hF0, 1);
  endtask

  // R8: same-cycle ordering
  task automatic t_order();
    do_reset();
    set_share(2, 2);
    pulse_tick();
    pg_valid = 1; pg_flow = 2; pg_data = 'h52; pg_eop = 1; tx_ready = 1;
    @(negedge clk);
    pg_valid = 0; tx_ready = 0;
    chk_page("R8 arrival before ready", 2, 'h52, 1);
    do_reset();
    push(1, 'h61, 1);
    cfg_we = 1; cfg_flow = 1; cfg_share = 3; tick = 1;
    @(negedge clk);
    cfg_we = 0; tick = 0;
    pulse_ready();
    chk_page("R8 share before tick", 1, 'h61, 1);
    do_reset();
    set_share(0, 1);
    push(0, 'h70, 1);
    tick = 1; tx_ready = 1;
    @(negedge clk);
    tick = 0; tx_ready = 0;
    chk_page("R8 tick before ready", 0, 'h70, 1);
  endtask

  // R9: ready during transmission ignored
  task automatic t_busy();
    do_reset();
    set_share(0, 5);
    set_share(1, 5);
    push(0, 'h80, 0);
    push(0, 'h81, 0);
    push(0, 'h82, 1);
    push(1, 'h90, 1);
    pulse_tick();
    pulse_ready();
    tx_ready = 1;
    chk_page("R9 page0", 0, 'h80, 0);
    tx_ready = 0;
    chk_page("R9 page1", 0, 'h81, 0);
    chk_page("R9 page2", 0, 'h82, 1);
    chk_idle("R9 busy ready ignored");
    pulse_ready();
    chk_page("R9 next choice", 1, 'h90, 1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_alloc_reasm();
    t_tie_charge();
    t_highest();
    t_cap();
    t_keep();
    t_order();
    t_busy();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule